// File: doc/BRIEF.md
# Link Controller Power-Up Sequencer

This block takes a serial-link root-port controller from cold reset to a trained link without software help. A single start pulse launches a fixed chain of steps. First every reset domain is put back into reset together. The block then asks the PLL to start and releases the APB and PHY domains. Next it enables the bus clock and the core A clock, releases core A, and enables the port clock. After that it drives a timed low pulse on the external port reset pin, turns on link training, and polls the link status at a fixed interval until the link reports up or the poll budget runs out.

The PLL, the clock generators and the training logic stay outside the block. Each of them answers a request with an acknowledge or status input. A request that is not acknowledged within a cycle budget, or a link that never comes up, ends the run in a failure state. All timed intervals are counted in microseconds from a prescaler whose division factor is a parameter, so the same block serves silicon clocks and short simulation settings.

Top module: `pcie_bringup_seq`

## Requirements
- R1: After reset, `rst_ctrl_o` is 0 (every domain held), `clk_en_o` is 0, `pll_req_o` is 0, `port_rst_n_o` is 1, `train_en_o` is 0, `done_o` and `err_o` are 0, and `state_o` is 0 (idle).
- R2: A start pulse seen in idle, done or failed state moves to the hold state (1) on the next edge. Hold clears all four reset bits and all clock enables and clears `done_o`/`err_o`. One cycle later it raises `pll_req_o` and enters the PLL wait state (2).
- R3: `rst_ctrl_o` bit 1 releases a domain and bit 0 holds it: bit 0 is core A, bit 1 core B, bit 2 APB, bit 3 PHY. On the PLL acknowledge, bits 2 and 3 are set together. Core B is never released.
- R4: `clk_en_o` bit 0 (bus clock) is raised one cycle after the APB/PHY release. Bit 1 (core A clock) is raised on the bit 0 acknowledge. Core A reset is released on the bit 1 acknowledge. Bit 2 (port clock) is raised one cycle later. Each `clk_ack_i` bit acknowledges the `clk_en_o` bit at the same position.
- R5: If the awaited acknowledge (PLL or clock) stays low for `ACK_TIMEOUT` consecutive cycles of a wait state, the block enters the failed state (12) with `err_o` = 1 and freezes all control outputs. An acknowledge in the last allowed cycle still counts.
- R6: On the port clock acknowledge, `port_rst_n_o` goes low for exactly `PORT_RST_US` × `US_CYCLES` cycles and then returns high.
- R7: `train_en_o` rises one cycle after `port_rst_n_o` returns high.
- R8: The link is sampled every `POLL_US` × `US_CYCLES` cycles after training starts. It counts as up only when `phy_up_i` and `dl_up_i` are both 1 and `link_state_i` equals `LINK_UP_CODE`. A sample that finds the link up moves to the done state (11) with `done_o` = 1.
- R9: After `POLL_MAX` samples that all find the link down, the block enters the failed state with `err_o` = 1.
- R10: A start pulse while the block is in any state other than idle, done or failed is ignored.
- R11: `done_o` and `err_o` are never both 1. Each stays 1 until the next accepted start or reset.
- R12: `state_o` encodes idle 0, hold 1, PLL wait 2, APB/PHY release 3, bus clock wait 4, core A clock wait 5, core A release 6, port clock wait 7, port reset pulse 8, pin release 9, polling 10, done 11, failed 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches the sequence from idle, done or failed |
| pll_req_o | output | 1 | PLL start request |
| pll_ack_i | input | 1 | PLL locked acknowledge |
| clk_en_o | output | 3 | Clock enable requests: bus, core A, port |
| clk_ack_i | input | 3 | Per-clock acknowledges |
| rst_ctrl_o | output | 4 | Domain reset control, 1 = released |
| port_rst_n_o | output | 1 | External port reset pin, active low |
| train_en_o | output | 1 | Link training enable |
| phy_up_i | input | 1 | Physical layer up flag |
| dl_up_i | input | 1 | Data link layer up flag |
| link_state_i | input | LINK_W | Training state machine code |
| done_o | output | 1 | Link up, sequence complete |
| err_o | output | 1 | Sequence ended in failure |
| state_o | output | 4 | Current step of the sequence |

## Verification
The bound checker watches the ordering rules on every cycle. It checks that core A leaves reset only with its clock running and the APB/PHY domains out, that the port clock follows core A, that training never starts before the pin is high, and that done rises only after a qualifying link sample. It also checks that done and error never overlap, that the pin pulse has the exact length, and that a start while busy never re-enters hold. The exact cycle of each transition, the acknowledge boundary, the poll budget and the rejection of partial link status are shown only by the bench scenarios against its reference model.

// File: rtl/pcie_bup_pkg.sv
package pcie_bup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_HOLD     = 4'd1,
        ST_PLL      = 4'd2,
        ST_REL_AP   = 4'd3,
        ST_CLK_BUS  = 4'd4,
        ST_CLK_CA   = 4'd5,
        ST_REL_CA   = 4'd6,
        ST_CLK_PORT = 4'd7,
        ST_PIN_LOW  = 4'd8,
        ST_PIN_HIGH = 4'd9,
        ST_POLL     = 4'd10,
        ST_DONE     = 4'd11,
        ST_FAIL     = 4'd12
    } seq_state_e;

    // reset control bit positions (1 = domain released)
    localparam int unsigned RB_CORE_A = 0;
    localparam int unsigned RB_CORE_B = 1;
    localparam int unsigned RB_APB    = 2;
    localparam int unsigned RB_PHY    = 3;
    localparam int unsigned RST_BITS  = 4;

    // clock enable bit positions
    localparam int unsigned CB_BUS    = 0;
    localparam int unsigned CB_CORE_A = 1;
    localparam int unsigned CB_PORT   = 2;
    localparam int unsigned CLK_BITS  = 3;

endpackage

// File: rtl/pcie_bup_tick.sv
// Microsecond prescaler: pulses tick_o once every DIV cycles, restarts on clr_i.
module pcie_bup_tick #(
    parameter int unsigned DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned W = $clog2(DIV + 1);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/pcie_bup_wait.sv
// Handshake wait budget: expired_o is high in the LIMIT-th cycle since clr_i.
module pcie_bup_wait #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic expired_o
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == LAST);

endmodule

// File: rtl/pcie_bup_linkchk.sv
// Three-condition link-up qualifier.
module pcie_bup_linkchk #(
    parameter int unsigned LINK_W       = 6,
    parameter int unsigned LINK_UP_CODE = 17
) (
    input  logic              phy_up_i,
    input  logic              dl_up_i,
    input  logic [LINK_W-1:0] link_state_i,
    output logic              up_o
);
    localparam logic [LINK_W-1:0] UP_CODE = LINK_W'(LINK_UP_CODE);

    assign up_o = phy_up_i && dl_up_i && (link_state_i == UP_CODE);

endmodule

// File: rtl/pcie_bringup_seq.sv
module pcie_bringup_seq
    import pcie_bup_pkg::*;
#(
    parameter int unsigned US_CYCLES    = 200,
    parameter int unsigned PORT_RST_US  = 10000,
    parameter int unsigned POLL_US      = 10,
    parameter int unsigned POLL_MAX     = 500000,
    parameter int unsigned ACK_TIMEOUT  = 1024,
    parameter int unsigned LINK_W       = 6,
    parameter int unsigned LINK_UP_CODE = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              pll_req_o,
    input  logic              pll_ack_i,
    output logic [2:0]        clk_en_o,
    input  logic [2:0]        clk_ack_i,
    output logic [3:0]        rst_ctrl_o,
    output logic              port_rst_n_o,
    output logic              train_en_o,
    input  logic              phy_up_i,
    input  logic              dl_up_i,
    input  logic [LINK_W-1:0] link_state_i,
    output logic              done_o,
    output logic              err_o,
    output logic [3:0]        state_o
);
    localparam int unsigned US_MAX = (PORT_RST_US > POLL_US) ? PORT_RST_US : POLL_US;
    localparam int unsigned US_W   = $clog2(US_MAX + 1);
    localparam int unsigned TRY_W  = $clog2(POLL_MAX + 1);
    localparam logic [US_W-1:0]  PIN_LAST  = US_W'(PORT_RST_US - 1);
    localparam logic [US_W-1:0]  POLL_LAST = US_W'(POLL_US - 1);
    localparam logic [TRY_W-1:0] TRY_LAST  = TRY_W'(POLL_MAX - 1);

    typedef struct packed {
        seq_state_e          st;
        logic [RST_BITS-1:0] rst;
        logic [CLK_BITS-1:0] cen;
        logic                pll;
        logic                pin_n;
        logic                train;
        logic                done;
        logic                err;
        logic [US_W-1:0]     us;
        logic [TRY_W-1:0]    tries;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic us_tick;
    logic ack_expired;
    logic link_up;
    logic phase_chg;

    assign phase_chg = (r_d.st != r_q.st);

    pcie_bup_tick #(.DIV(US_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (phase_chg),
        .tick_o (us_tick)
    );

    pcie_bup_wait #(.LIMIT(ACK_TIMEOUT)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (phase_chg),
        .expired_o (ack_expired)
    );

    pcie_bup_linkchk #(.LINK_W(LINK_W), .LINK_UP_CODE(LINK_UP_CODE)) u_link (
        .phy_up_i     (phy_up_i),
        .dl_up_i      (dl_up_i),
        .link_state_i (link_state_i),
        .up_o         (link_up)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start_i) begin
                    r_d.st    = ST_HOLD;
                    r_d.rst   = '0;
                    r_d.cen   = '0;
                    r_d.pll   = 1'b0;
                    r_d.pin_n = 1'b1;
                    r_d.train = 1'b0;
                    r_d.done  = 1'b0;
                    r_d.err   = 1'b0;
                end
            end
            ST_HOLD: begin
                r_d.st  = ST_PLL;
                r_d.pll = 1'b1;
            end
            ST_PLL: begin
                if (pll_ack_i) begin
                    r_d.st          = ST_REL_AP;
                    r_d.rst[RB_APB] = 1'b1;
                    r_d.rst[RB_PHY] = 1'b1;
                end else if (ack_expired) begin
                    r_d.st  = ST_FAIL;
                    r_d.err = 1'b1;
                end
            end
            ST_REL_AP: begin
                r_d.st          = ST_CLK_BUS;
                r_d.cen[CB_BUS] = 1'b1;
            end
            ST_CLK_BUS: begin
                if (clk_ack_i[CB_BUS]) begin
                    r_d.st             = ST_CLK_CA;
                    r_d.cen[CB_CORE_A] = 1'b1;
                end else if (ack_expired) begin
                    r_d.st  = ST_FAIL;
                    r_d.err = 1'b1;
                end
            end
            ST_CLK_CA: begin
                if (clk_ack_i[CB_CORE_A]) begin
                    r_d.st             = ST_REL_CA;
                    r_d.rst[RB_CORE_A] = 1'b1;
                end else if (ack_expired) begin
                    r_d.st  = ST_FAIL;
                    r_d.err = 1'b1;
                end
            end
            ST_REL_CA: begin
                r_d.st           = ST_CLK_PORT;
                r_d.cen[CB_PORT] = 1'b1;
            end
            ST_CLK_PORT: begin
                if (clk_ack_i[CB_PORT]) begin
                    r_d.st    = ST_PIN_LOW;
                    r_d.pin_n = 1'b0;
                    r_d.us    = '0;
                end else if (ack_expired) begin
                    r_d.st  = ST_FAIL;
                    r_d.err = 1'b1;
                end
            end
            ST_PIN_LOW: begin
                if (us_tick) begin
                    if (r_q.us == PIN_LAST) begin
                        r_d.st    = ST_PIN_HIGH;
                        r_d.pin_n = 1'b1;
                    end else begin
                        r_d.us = r_q.us + 1'b1;
                    end
                end
            end
            ST_PIN_HIGH: begin
                r_d.st    = ST_POLL;
                r_d.train = 1'b1;
                r_d.us    = '0;
                r_d.tries = '0;
            end
            ST_POLL: begin
                if (us_tick) begin
                    if (r_q.us == POLL_LAST) begin
                        r_d.us = '0;
                        if (link_up) begin
                            r_d.st   = ST_DONE;
                            r_d.done = 1'b1;
                        end else if (r_q.tries == TRY_LAST) begin
                            r_d.st  = ST_FAIL;
                            r_d.err = 1'b1;
                        end else begin
                            r_d.tries = r_q.tries + 1'b1;
                        end
                    end else begin
                        r_d.us = r_q.us + 1'b1;
                    end
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, rst: '0, cen: '0, pll: 1'b0, pin_n: 1'b1,
                     train: 1'b0, done: 1'b0, err: 1'b0, us: '0, tries: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign pll_req_o    = r_q.pll;
    assign clk_en_o     = r_q.cen;
    assign rst_ctrl_o   = r_q.rst;
    assign port_rst_n_o = r_q.pin_n;
    assign train_en_o   = r_q.train;
    assign done_o       = r_q.done;
    assign err_o        = r_q.err;
    assign state_o      = r_q.st;

endmodule

// File: rtl/pcie_bup_chk.sv
module pcie_bup_chk #(
    parameter int unsigned PULSE_CYCLES = 2000000,
    parameter int unsigned LINK_W       = 6,
    parameter int unsigned LINK_UP_CODE = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              pll_ack_i,
    input logic [2:0]        clk_en_o,
    input logic [3:0]        rst_ctrl_o,
    input logic              port_rst_n_o,
    input logic              train_en_o,
    input logic              phy_up_i,
    input logic              dl_up_i,
    input logic [LINK_W-1:0] link_state_i,
    input logic              done_o,
    input logic              err_o,
    input logic [3:0]        state_o
);
    localparam logic [3:0] S_IDLE = 4'd0;
    localparam logic [3:0] S_HOLD = 4'd1;
    localparam logic [3:0] S_DONE = 4'd11;
    localparam logic [3:0] S_FAIL = 4'd12;

    int unsigned low_cnt;
    logic        busy;

    assign busy = (state_o != S_IDLE) && (state_o != S_DONE) && (state_o != S_FAIL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= 0;
        end else if (!port_rst_n_o) begin
            low_cnt <= low_cnt + 1;
        end else begin
            low_cnt <= 0;
        end
    end

    // R3: APB and PHY leave reset together, only after the PLL acknowledge
    a_r3_apb_phy_after_pll: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_ctrl_o[3]) |-> (rst_ctrl_o[2] && $past(pll_ack_i)));

    // R4: core A leaves reset only with its clock on and APB/PHY already out
    a_r4_core_a_after_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_ctrl_o[0]) |-> (clk_en_o[1] && rst_ctrl_o[3:2] == 2'b11 && !rst_ctrl_o[1]));

    // R4: port clock only after core A release and both earlier clocks
    a_r4_port_clock_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en_o[2]) |-> (rst_ctrl_o[0] && clk_en_o[1:0] == 2'b11));

    // R6: pin pulse length
    a_r6_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_rst_n_o) |-> (low_cnt == PULSE_CYCLES));

    // R7: training follows the pin release
    a_r7_train_after_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en_o) |-> (port_rst_n_o && $past(port_rst_n_o)));

    // R8: done only after a full link-up sample
    a_r8_done_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(phy_up_i && dl_up_i && link_state_i == LINK_W'(LINK_UP_CODE)));

    // R10: start while busy never re-enters hold
    a_r10_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> (state_o != S_HOLD));

    // R11: outcomes exclusive and held
    a_r11_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    a_r11_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    a_r11_err_held: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o);

endmodule

bind pcie_bringup_seq pcie_bup_chk #(
    .PULSE_CYCLES (PORT_RST_US * US_CYCLES),
    .LINK_W       (LINK_W),
    .LINK_UP_CODE (LINK_UP_CODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .pll_ack_i    (pll_ack_i),
    .clk_en_o     (clk_en_o),
    .rst_ctrl_o   (rst_ctrl_o),
    .port_rst_n_o (port_rst_n_o),
    .train_en_o   (train_en_o),
    .phy_up_i     (phy_up_i),
    .dl_up_i      (dl_up_i),
    .link_state_i (link_state_i),
    .done_o       (done_o),
    .err_o        (err_o),
    .state_o      (state_o)
);

// File: tb/pcie_bringup_seq_test.sv
`timescale 1ns/1ps
module pcie_bringup_seq_test;

    localparam int US    = 2;
    localparam int PINUS = 3;
    localparam int PUS   = 2;
    localparam int PMAX  = 3;
    localparam int ACK   = 5;
    localparam int UPC   = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       pll_req_o, pll_ack_i;
    logic [2:0] clk_en_o, clk_ack_i;
    logic [3:0] rst_ctrl_o;
    logic       port_rst_n_o, train_en_o;
    logic       phy_up_i, dl_up_i;
    logic [5:0] link_state_i;
    logic       done_o, err_o;
    logic [3:0] state_o;

    always #2.5 clk = ~clk;

    pcie_bringup_seq #(
        .US_CYCLES(US), .PORT_RST_US(PINUS), .POLL_US(PUS), .POLL_MAX(PMAX),
        .ACK_TIMEOUT(ACK), .LINK_W(6), .LINK_UP_CODE(UPC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .pll_req_o(pll_req_o), .pll_ack_i(pll_ack_i),
        .clk_en_o(clk_en_o), .clk_ack_i(clk_ack_i),
        .rst_ctrl_o(rst_ctrl_o), .port_rst_n_o(port_rst_n_o), .train_en_o(train_en_o),
        .phy_up_i(phy_up_i), .dl_up_i(dl_up_i), .link_state_i(link_state_i),
        .done_o(done_o), .err_o(err_o), .state_o(state_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // environment knobs (-1 = never acknowledge)
    int pll_dly = 1;
    int cdly [3] = '{2, 0, 1};
    int link_dly = 3;
    int link_mode = 0;   // 0 good, 1 data-link flag stuck low, 2 wrong training code
    int plow = 0;
    int twin = 0;

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        end
    endtask

    // reference model: phase number plus cycles spent in the phase
    int         m_ph = 0;
    int         m_cyc = 0;
    logic [3:0] m_rst = '0;
    logic [2:0] m_cen = '0;
    logic       m_pll = 0, m_pin = 1, m_train = 0, m_done = 0, m_err = 0;

    initial forever begin
        @(posedge clk);
        if (!rst_n) begin
            m_ph = 0; m_cyc = 0; m_rst = '0; m_cen = '0;
            m_pll = 0; m_pin = 1; m_train = 0; m_done = 0; m_err = 0;
        end else begin : step
            int nx;
            bit lk;
            int win;
            nx  = m_ph;
            lk  = phy_up_i && dl_up_i && (link_state_i == 6'(UPC));
            win = PUS * US;
            case (m_ph)
                0, 11, 12: if (start_i) begin
                    nx = 1; m_rst = '0; m_cen = '0; m_pll = 0; m_pin = 1;
                    m_train = 0; m_done = 0; m_err = 0;
                end
                1: begin nx = 2; m_pll = 1; end
                2: if (pll_ack_i) begin nx = 3; m_rst[3] = 1; m_rst[2] = 1; end
                   else if (m_cyc == ACK - 1) begin nx = 12; m_err = 1; end
                3: begin nx = 4; m_cen[0] = 1; end
                4: if (clk_ack_i[0]) begin nx = 5; m_cen[1] = 1; end
                   else if (m_cyc == ACK - 1) begin nx = 12; m_err = 1; end
                5: if (clk_ack_i[1]) begin nx = 6; m_rst[0] = 1; end
                   else if (m_cyc == ACK - 1) begin nx = 12; m_err = 1; end
                6: begin nx = 7; m_cen[2] = 1; end
                7: if (clk_ack_i[2]) begin nx = 8; m_pin = 0; end
                   else if (m_cyc == ACK - 1) begin nx = 12; m_err = 1; end
                8: if (m_cyc == PINUS * US - 1) begin nx = 9; m_pin = 1; end
                9: begin nx = 10; m_train = 1; end
                10: if ((m_cyc + 1) % win == 0) begin
                    if (lk) begin nx = 11; m_done = 1; end
                    else if ((m_cyc + 1) / win == PMAX) begin nx = 12; m_err = 1; end
                end
                default: nx = 0;
            endcase
            m_cyc = (nx == m_ph) ? m_cyc + 1 : 0;
            m_ph  = nx;
        end
    end

    // responder, per-cycle comparison and measurement, away from the active edge
    initial begin : env
        int pc;
        int cc [3];
        int tc;
        pc = 0; cc = '{0, 0, 0}; tc = 0;
        pll_ack_i = 0; clk_ack_i = '0; phy_up_i = 0; dl_up_i = 0; link_state_i = 6'd5;
        forever begin
            @(negedge clk);
            pc = pll_req_o ? pc + 1 : 0;
            pll_ack_i = (pll_dly >= 0) && (pc > pll_dly);
            for (int i = 0; i < 3; i++) begin
                cc[i] = clk_en_o[i] ? cc[i] + 1 : 0;
                clk_ack_i[i] = (cdly[i] >= 0) && (cc[i] > cdly[i]);
            end
            tc = train_en_o ? tc + 1 : 0;
            phy_up_i     = (tc > link_dly);
            dl_up_i      = (tc > link_dly) && (link_mode != 1);
            link_state_i = (tc <= link_dly) ? 6'd5 : ((link_mode == 2) ? 6'd16 : 6'(UPC));
            if (!port_rst_n_o) plow++;
            if (train_en_o && !err_o && !done_o) twin++;
            if (rst_n) begin
                chk_eq("R12 state_o", state_o, m_ph);
                chk_eq("R3 rst_ctrl_o", rst_ctrl_o, m_rst);
                chk_eq("R4 clk_en_o", clk_en_o, m_cen);
                chk_eq("R2 pll_req_o", pll_req_o, m_pll);
                chk_eq("R6 port_rst_n_o", port_rst_n_o, m_pin);
                chk_eq("R7 train_en_o", train_en_o, m_train);
                chk_eq("R8 done_o", done_o, m_done);
                chk_eq("R5 err_o", err_o, m_err);
            end
        end
    end

    task automatic run_seq();
        int n;
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0;
        n = 0;
        while (!(done_o || err_o) && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk_eq("R1 rst_ctrl", rst_ctrl_o, 0);
        chk_eq("R1 clk_en", clk_en_o, 0);
        chk_eq("R1 pll_req", pll_req_o, 0);
        chk_eq("R1 port pin", port_rst_n_o, 1);
        chk_eq("R1 train", train_en_o, 0);
        chk_eq("R1 done/err", {done_o, err_o}, 0);
        chk_eq("R1 state", state_o, 0);

        // normal bring-up
        plow = 0;
        run_seq();
        chk_eq("R8 done after link up", done_o, 1);
        chk_eq("R6 pin low cycles", plow, PINUS * US);
        chk_eq("R3 final resets (core B held)", rst_ctrl_o, 4'b1101);
        chk_eq("R4 all clocks on", clk_en_o, 3'b111);
        chk_eq("R7 training on", train_en_o, 1);

        // R11: done holds; R10: start while busy ignored
        repeat (10) @(negedge clk);
        chk_eq("R11 done held", done_o, 1);
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0;
        chk_eq("R11 start clears done", done_o, 0);
        chk_eq("R2 hold state", state_o, 1);
        chk_eq("R2 all resets held", rst_ctrl_o, 0);
        repeat (3) @(negedge clk);
        start_i = 1;
        @(negedge clk) start_i = 0;
        chk_eq("R10 busy start ignored", state_o, 4);
        while (!(done_o || err_o)) @(negedge clk);
        chk_eq("R10 sequence completed", done_o, 1);

        // R5: PLL never acknowledges
        pll_dly = -1;
        run_seq();
        chk_eq("R5 pll timeout err", err_o, 1);
        chk_eq("R5 failed state", state_o, 12);
        chk_eq("R5 pll_req frozen", pll_req_o, 1);
        chk_eq("R5 resets still held", rst_ctrl_o, 0);
        repeat (5) @(negedge clk);
        chk_eq("R11 err held", err_o, 1);

        // R5 boundary: acknowledge in the last allowed cycle
        pll_dly = 0;
        cdly[0] = ACK - 1;
        run_seq();
        chk_eq("R5 late ack accepted", done_o, 1);
        cdly[0] = ACK;
        run_seq();
        chk_eq("R5 ack one cycle late", err_o, 1);
        chk_eq("R5 only bus clock on", clk_en_o, 3'b001);

        // R9: data-link flag never rises
        cdly[0] = 0;
        link_mode = 1;
        twin = 0;
        run_seq();
        chk_eq("R9 poll budget exhausted", err_o, 1);
        chk_eq("R9 polling cycles", twin, PMAX * PUS * US);

        // R8: both flags up but training code wrong
        link_mode = 2;
        run_seq();
        chk_eq("R8 wrong code rejected err", err_o, 1);
        chk_eq("R8 wrong code no done", done_o, 0);

        // R11: restart from failure
        link_mode = 0;
        run_seq();
        chk_eq("R11 restart done", done_o, 1);
        chk_eq("R11 restart err cleared", err_o, 0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule